// File: doc/BRIEF.md
# SPI Serial-Clock Prescaler

This block turns the core clock into the timing of an SPI serial clock. A prescale byte from the configuration register sets how many core cycles one SCK period lasts. While an exchange is active, the block produces three outputs. The first is a one-cycle strobe at every SCK edge point, used by the shifter to launch and capture data. The second is a one-cycle strobe at the end of every full SCK period. The third is the SCK level itself. A parameter fixes how the prescale byte is read, and there are two choices.

The linear encoding gives an even divisor of twice the low nibble. The scaled encoding multiplies a 4-bit factor by a power of two, using a 3-bit exponent whose bits sit in non-adjacent positions of the byte. This gives divisors up to 1920. The divisor in use is captured while the bus is idle. During an exchange, a new value is taken only at a full-period boundary that the shifter marks as the end of a word. Picking a prescale byte for a target bit rate is left to software.

Top module: `spi_sck_prescaler`

## Requirements
- R1: With the linear encoding, the divisor D is 2*cfg[3:0]. A nibble value of 0 or 1 gives D = 4. Bits [7:4] have no effect.
- R2: With the scaled encoding, D = max(cfg[3:0], 2) * 2^E, where E = {cfg[7], cfg[6], cfg[4]} (cfg[4] is the least significant exponent bit). Bit 5 has no effect.
- R3: While `xfer_active` is high, `sck_tick` pulses for one cycle every D core cycles. The first pulse comes in the D-th active cycle, counting from 1, and two pulses never fall in adjacent cycles.
- R4: `sck_toggle` pulses at the end of the first half-period, which lasts D - floor(D/2) cycles, and again at the end of each full period. For odd D the first half is the longer one.
- R5: `sck` equals `cpol` during the first half of each period and its inverse during the second half. It changes in the cycle after each `sck_toggle` pulse and at no other time while active.
- R6: While `xfer_active` is low, `sck` rests at `cpol` and neither strobe fires. Each activation starts a fresh period from its first cycle.
- R7: A prescale change made while active takes effect only after a `sck_tick` cycle in which `word_end` is high. Until then the old divisor is kept.
- R8: After reset, `sck` equals `cpol`, and `sck_toggle` and `sck_tick` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| presc_cfg | input | CFG_W (8) | Prescale byte from the configuration register |
| cpol | input | 1 | SCK idle level |
| xfer_active | input | 1 | High while an exchange runs |
| word_end | input | 1 | Shifter marks the current period as the last of a word |
| sck | output | 1 | Serial clock level |
| sck_toggle | output | 1 | One-cycle strobe at each half-period boundary |
| sck_tick | output | 1 | One-cycle strobe at each full-period boundary |

## Verification
A wrong captured divisor appears as a wrong tick spacing within the very first period after activation. It is caught by comparing the measured period with the divisor computed from the byte. A half-period counter that misloads moves the first toggle away from cycle ceil(D/2), and a stuck level register leaves `sck` wrong one cycle after a toggle. A divisor latch that updates at the wrong moment stretches or shortens the first interval after a mid-word write, which shows within two periods. Every byte value is swept in both encodings, so a miswired exponent bit or a missing clamp shows up as a wrong period for some byte.

// File: rtl/spi_presc_pkg.sv
package spi_presc_pkg;

   typedef enum logic {
      ENC_LINEAR = 1'b0,
      ENC_SCALED = 1'b1
   } presc_enc_e;

   // Widest divisor: a (2^spr_w - 1) factor shifted by up to 2^exp_w - 1.
   function automatic int unsigned div_width(int unsigned spr_w, int unsigned exp_w);
      return spr_w + (1 << exp_w) - 1;
   endfunction

endpackage

// File: rtl/presc_decode.sv
module presc_decode
   import spi_presc_pkg::*;
#(
   parameter presc_enc_e ENC   = ENC_SCALED,
   parameter int unsigned CFG_W = 8,
   parameter int unsigned SPR_W = 4,
   parameter int unsigned EXP_W = 3,
   parameter int unsigned DIV_W = div_width(SPR_W, EXP_W)
) (
   input  logic [CFG_W-1:0] cfg,
   output logic [DIV_W-1:0] div
);

   localparam logic [SPR_W-1:0] FACTOR_MIN = SPR_W'(2);

   logic [SPR_W-1:0] factor;

   // Factor below 2 would give a zero-length half period.
   always_comb begin
      factor = cfg[SPR_W-1:0];
      if (factor < FACTOR_MIN) factor = FACTOR_MIN;
   end

   generate
      if (ENC == ENC_SCALED) begin : g_scaled
         logic [EXP_W-1:0] expo;
         // Exponent LSB sits just above the factor; upper bits skip one position.
         assign expo = {cfg[SPR_W+3:SPR_W+2], cfg[SPR_W]};
         assign div  = DIV_W'(factor) << expo;
      end else begin : g_linear
         assign div = DIV_W'({factor, 1'b0});
      end
   endgenerate

endmodule

// File: rtl/presc_counter.sv
module presc_counter #(
   parameter int unsigned DIV_W = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             active,
   input  logic [DIV_W-1:0] div,
   output logic             toggle,
   output logic             tick
);

   logic [DIV_W-1:0] half_first;
   logic [DIV_W-1:0] half_second;
   logic [DIV_W-1:0] last;
   logic [DIV_W-1:0] cnt;
   logic             phase;
   logic             at_end;

   // Odd divisors give the extra cycle to the first half.
   assign half_second = div >> 1;
   assign half_first  = div - half_second;
   assign last        = phase ? (half_second - DIV_W'(1)) : (half_first - DIV_W'(1));
   assign at_end      = (cnt == last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         phase <= 1'b0;
      end else if (!active) begin
         cnt   <= '0;
         phase <= 1'b0;
      end else if (at_end) begin
         cnt   <= '0;
         phase <= ~phase;
      end else begin
         cnt   <= cnt + DIV_W'(1);
      end
   end

   assign toggle = active & at_end;
   assign tick   = toggle & phase;

endmodule

// File: rtl/sck_level.sv
module sck_level (
   input  logic clk,
   input  logic rst_n,
   input  logic active,
   input  logic toggle,
   input  logic cpol,
   output logic sck
);

   logic inverted;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       inverted <= 1'b0;
      else if (!active) inverted <= 1'b0;
      else if (toggle)  inverted <= ~inverted;
   end

   assign sck = cpol ^ inverted;

endmodule

// File: rtl/spi_sck_prescaler.sv
module spi_sck_prescaler
   import spi_presc_pkg::*;
#(
   parameter presc_enc_e ENC   = ENC_SCALED,
   parameter int unsigned CFG_W = 8,
   parameter int unsigned SPR_W = 4,
   parameter int unsigned EXP_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CFG_W-1:0] presc_cfg,
   input  logic             cpol,
   input  logic             xfer_active,
   input  logic             word_end,
   output logic             sck,
   output logic             sck_toggle,
   output logic             sck_tick
);

   localparam int unsigned DIV_W = div_width(SPR_W, EXP_W);
   localparam logic [DIV_W-1:0] DIV_RESET = DIV_W'(4);

   generate
      if (EXP_W != 3) begin : g_bad_exp
         $error("exponent field layout needs EXP_W == 3");
      end
      if (CFG_W < SPR_W + 4) begin : g_bad_cfg
         $error("prescale byte too narrow for the field layout");
      end
   endgenerate

   logic [DIV_W-1:0] div_dec;
   logic [DIV_W-1:0] div_q;

   presc_decode #(
      .ENC   (ENC),
      .CFG_W (CFG_W),
      .SPR_W (SPR_W),
      .EXP_W (EXP_W),
      .DIV_W (DIV_W)
   ) u_decode (
      .cfg (presc_cfg),
      .div (div_dec)
   );

   // Divisor is only replaced while idle or at a word boundary.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                 div_q <= DIV_RESET;
      else if (!xfer_active || (sck_tick && word_end)) div_q <= div_dec;
   end

   presc_counter #(
      .DIV_W (DIV_W)
   ) u_counter (
      .clk    (clk),
      .rst_n  (rst_n),
      .active (xfer_active),
      .div    (div_q),
      .toggle (sck_toggle),
      .tick   (sck_tick)
   );

   sck_level u_level (
      .clk    (clk),
      .rst_n  (rst_n),
      .active (xfer_active),
      .toggle (sck_toggle),
      .cpol   (cpol),
      .sck    (sck)
   );

endmodule

// File: rtl/spi_sck_prescaler_chk.sv
module spi_sck_prescaler_chk #(
   parameter int unsigned CFG_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic [CFG_W-1:0] presc_cfg,
   input logic             cpol,
   input logic             xfer_active,
   input logic             word_end,
   input logic             sck,
   input logic             sck_toggle,
   input logic             sck_tick
);

   assert_idle_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !xfer_active |=> (sck == cpol));

   assert_no_strobe_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !xfer_active |-> (!sck_toggle && !sck_tick));

   assert_sck_flips_R5: assert property (@(posedge clk) disable iff (!rst_n)
      sck_toggle |=> ((sck ^ cpol) != $past(sck ^ cpol)));

   assert_sck_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_active && !sck_toggle) |=> ((sck ^ cpol) == $past(sck ^ cpol)));

   assert_tick_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
      sck_tick |=> !sck_tick);

endmodule

bind spi_sck_prescaler spi_sck_prescaler_chk #(.CFG_W(CFG_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .presc_cfg   (presc_cfg),
   .cpol        (cpol),
   .xfer_active (xfer_active),
   .word_end    (word_end),
   .sck         (sck),
   .sck_toggle  (sck_toggle),
   .sck_tick    (sck_tick)
);

// File: tb/tb_spi_sck_prescaler.sv
module tb_spi_sck_prescaler;
   import spi_presc_pkg::*;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] cfg = 8'h00;
   logic       cpol = 1'b0;
   logic       word_end = 1'b0;
   logic       act_s = 1'b0;
   logic       act_l = 1'b0;
   logic       sel = 1'b1;

   logic sck_s, tog_s, tick_s;
   logic sck_l, tog_l, tick_l;
   logic sck_o, tog_o, tick_o;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   spi_sck_prescaler #(.ENC(ENC_SCALED)) dut (
      .clk (clk), .rst_n (rst_n), .presc_cfg (cfg), .cpol (cpol),
      .xfer_active (act_s), .word_end (word_end),
      .sck (sck_s), .sck_toggle (tog_s), .sck_tick (tick_s)
   );

   spi_sck_prescaler #(.ENC(ENC_LINEAR)) dut_linear (
      .clk (clk), .rst_n (rst_n), .presc_cfg (cfg), .cpol (cpol),
      .xfer_active (act_l), .word_end (word_end),
      .sck (sck_l), .sck_toggle (tog_l), .sck_tick (tick_l)
   );

   assign sck_o  = sel ? sck_s  : sck_l;
   assign tog_o  = sel ? tog_s  : tog_l;
   assign tick_o = sel ? tick_s : tick_l;

   task automatic check(input bit ok, input string tag, input int actual, input int expected);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, actual, expected);
      end
   endtask

   function automatic int exp_div(input bit scaled, input logic [7:0] c);
      int f;
      f = (c[3:0] < 2) ? 2 : int'(c[3:0]);
      if (scaled) return f << {c[7], c[6], c[4]};
      return 2 * f;
   endfunction

   task automatic set_act(input bit scaled, input bit v);
      if (scaled) act_s = v;
      else        act_l = v;
   endtask

   // One period from a fresh activation; checks period, first toggle, levels.
   task automatic run_one(input bit scaled, input logic [7:0] c, input bit pol);
      int d, a, first_tog, tick_k, sck0, sck_a;
      @(negedge clk);
      sel = scaled; cfg = c; cpol = pol; act_s = 0; act_l = 0;
      @(negedge clk);
      set_act(scaled, 1'b1);
      #1;
      d = exp_div(scaled, c);
      a = d - d / 2;
      first_tog = -1; tick_k = -1; sck0 = int'(sck_o); sck_a = -1;
      for (int k = 0; k < 4000; k++) begin
         if (k == a) sck_a = int'(sck_o);
         if (tog_o && first_tog < 0) first_tog = k;
         if (tick_o) begin tick_k = k; break; end
         @(negedge clk); #1;
      end
      check(tick_k == d - 1, scaled ? "R2 period" : "R1 period", tick_k + 1, d);
      check(first_tog == a - 1, "R4 first half", first_tog + 1, a);
      check(sck0 == int'(pol) && sck_a == int'(!pol), "R5 level", sck0 * 2 + sck_a, int'(pol) * 2 + int'(!pol));
      @(negedge clk);
      set_act(scaled, 1'b0);
   endtask

   task automatic wait_tick(output int n);
      n = 0;
      for (int k = 0; k < 4000; k++) begin
         n++;
         if (tick_o) break;
         @(negedge clk); #1;
      end
      @(negedge clk); #1;
   endtask

   initial begin : watchdog
      for (int i = 0; i < 190000; i++) begin
         @(posedge clk);
         if (done) disable watchdog;
      end
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      int n1, n2, n3, n4;
      cpol = 1'b1;
      repeat (3) @(negedge clk);
      #1;
      // R8: reset state
      sel = 1'b1;
      check(sck_o == 1'b1 && !tog_o && !tick_o, "R8 reset scaled", int'(sck_o), 1);
      sel = 1'b0;
      check(sck_l == 1'b1 && !tog_l && !tick_l, "R8 reset linear", int'(sck_l), 1);
      @(negedge clk);
      rst_n = 1'b1;

      // R1: linear encoding, every byte
      for (int c = 0; c < 256; c++) run_one(1'b0, 8'(c), c[0] ^ c[5]);
      // R2: scaled encoding, every byte
      for (int c = 0; c < 256; c++) run_one(1'b1, 8'(c), c[1] ^ c[5]);

      // R6: abort mid-period, idle level, then a fresh full period
      @(negedge clk);
      sel = 1'b1; cfg = 8'h05; cpol = 1'b1;
      @(negedge clk); act_s = 1'b1;
      repeat (4) @(negedge clk);
      act_s = 1'b0;
      repeat (2) @(negedge clk);
      #1;
      check(sck_o == 1'b1 && !tog_o && !tick_o, "R6 idle level", int'(sck_o), 1);
      cpol = 1'b0;
      #1;
      check(sck_o == 1'b0, "R6 idle follows cpol", int'(sck_o), 0);
      run_one(1'b1, 8'h05, 1'b1);

      // R7: mid-word write held until a tick with word_end
      @(negedge clk);
      sel = 1'b0; cfg = 8'h02; cpol = 1'b0; word_end = 1'b0;
      @(negedge clk); act_l = 1'b1;
      #1;
      cfg = 8'h05;
      wait_tick(n1);
      check(n1 == 4, "R7 first interval old", n1, 4);
      wait_tick(n2);
      check(n2 == 4, "R7 no word_end keeps old", n2, 4);
      word_end = 1'b1;
      wait_tick(n3);
      word_end = 1'b0;
      check(n3 == 4, "R7 boundary interval", n3, 4);
      wait_tick(n4);
      check(n4 == 10, "R7 new divisor after boundary", n4, 10);
      act_l = 1'b0;

      // R3: consecutive ticks at the smallest scaled divisor (D=2)
      @(negedge clk);
      sel = 1'b1; cfg = 8'h00;
      @(negedge clk); act_s = 1'b1;
      #1;
      wait_tick(n1);
      wait_tick(n2);
      check(n1 == 2 && n2 == 2, "R3 repeated period", n2, 2);
      act_s = 1'b0;

      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule